// File: doc/BRIEF.md
# Packet receive FIFO channel

This block terminates an incoming AXI4-Stream and turns it into packets that software pulls out through a small read-only register window. Each accepted beat puts one 32-bit word into a word store. When the beat that carries tlast is accepted, two more things are recorded for the packet. Its byte length goes into a length queue, and its destination goes into a destination queue.

Software handles one packet in a fixed order. It first reads the length register. That read hands the oldest complete packet to the reader and arms a word budget equal to the length rounded up to whole words. It then pulls data words one at a time from the data register. The destination register may be read once per packet. An occupancy register reports the number of stored words plus one slot that stands for the packet length.

Reads that break the sequence raise a one-cycle error pulse. A receive reset empties the whole channel at once.

The stream side follows valid/ready rules. A beat transfers on a rising clock edge where both `s_tvalid` and `s_tready` are high. `s_tready` is low while the word store holds its full data capacity (DEPTH-1 words), while either packet queue is full, or while `rx_reset` is high. The sender must hold its beat until it is taken, so no stream data is ever dropped.

Top module: `rxq_chan`

## Requirements
- R1: After reset, and with no traffic, `s_tready` is 1. An occupancy read (offset 0x1C) returns 1. A length read (0x24) returns 0, and a destination read (0x30) returns 0. None of these reads raises an error flag.
- R2: An occupancy read returns the number of words stored and not yet read or discarded, plus 1. This count includes the words of a packet that is still incomplete.
- R3: `s_tready` is 0 whenever DEPTH-1 words are stored, or FRAMES complete packets are waiting for a length read. No beat is lost when this happens.
- R4: `evt_rx_done` is 1 for exactly the one cycle after the edge that accepts a beat with tlast, and 0 after every other accepted beat.
- R5: A length read returns the byte length of the oldest complete packet that has not yet been handed over. The length is 4*(beats-1) plus the number of set bits of the last beat's tkeep. Earlier beats count as four bytes each. If no complete packet is waiting, the read returns 0.
- R6: After a length read of L bytes, the next ceil(L/4) data reads (offset 0x20) return that packet's words in arrival order.
- R7: A data read made when the store is not empty but the word budget is 0 returns 0, removes no word and pulses `err_over_read`. This covers a read before any length read and a read beyond the length.
- R8: A data read made while the store is empty returns 0 and pulses `err_empty`. This check takes priority over R7.
- R9: A length read made while words of the current packet are still unread discards those words and pulses `err_under_read`. It then hands over the next packet as in R5.
- R10: A destination read returns the tdest of the last beat of the oldest packet whose destination has not yet been read. The next value takes its place only after that read. With nothing queued, the read returns 0.
- R11: While `rx_reset` is high, all stored words, both queues, the word budget and any partly received packet are thrown away. Afterwards the state of R1 holds, and lengths restart from zero.
- R12: Register data appears on `rd_data` in the cycle after the `rd_en` edge, and the error pulses appear in the same cycle. Any other offset returns 0 and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_reset | input | 1 | Synchronous receive reset, drops all content |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream ready, low while full or in receive reset |
| s_tdata | input | 32 | Stream data word |
| s_tkeep | input | 4 | Byte enables, only meaningful on the last beat |
| s_tlast | input | 1 | Last beat of packet |
| s_tdest | input | DESTW | Packet destination, taken from the last beat |
| rd_en | input | 1 | Register read strobe, one cycle per read |
| rd_addr | input | 8 | Register byte offset |
| rd_data | output | 32 | Registered read data |
| evt_rx_done | output | 1 | Pulse: a complete packet was stored |
| err_over_read | output | 1 | Pulse: data read with no word budget |
| err_under_read | output | 1 | Pulse: length read discarded unread words |
| err_empty | output | 1 | Pulse: data read from an empty store |

## Verification
A wrong pointer or count in the word store shows up as a wrong occupancy value, or as data words out of order, at the very next register read. It shows up later as a stall of `s_tready` when the store is not really full. A word budget that is off by one either raises an error pulse early or returns a word from the next packet one read too soon. That becomes visible in the cycle after the data read. A queue that slips shows a wrong length or destination on the following length or destination read. A receive reset that leaves state behind shows a non-unity occupancy, or a length that includes discarded beats, on the first packet received afterwards.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // register byte offsets decoded by the reader
  localparam logic [7:0] OFS_OCC  = 8'h1C;
  localparam logic [7:0] OFS_DATA = 8'h20;
  localparam logic [7:0] OFS_LEN  = 8'h24;
  localparam logic [7:0] OFS_DEST = 8'h30;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_OCC,
    SEL_DATA,
    SEL_LEN,
    SEL_DEST
  } sel_e;

  function automatic sel_e decode_sel(input logic [7:0] a);
    sel_e s;
    case (a)
      OFS_OCC:  s = SEL_OCC;
      OFS_DATA: s = SEL_DATA;
      OFS_LEN:  s = SEL_LEN;
      OFS_DEST: s = SEL_DEST;
      default:  s = SEL_NONE;
    endcase
    return s;
  endfunction

  // number of valid bytes in a 4-lane beat
  function automatic logic [2:0] keep_bytes(input logic [3:0] k);
    logic [2:0] n;
    n = '0;
    for (int i = 0; i < 4; i++) n = n + {2'b00, k[i]};
    return n;
  endfunction

endpackage

// File: rtl/rxq_fifo.sv
// Small queue used for per-packet lengths and destinations.
module rxq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = mem[rp];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp] <= din;
  end

endmodule

// File: rtl/rxq_store.sv
// Word store: one slot of DEPTH stands for the length, so DEPTH-1 data words fit.
// DEPTH must be a power of two; a multi-word discard is a single pointer jump.
module rxq_store #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [31:0]   din,
  input  logic          pop,
  input  logic          skip,
  input  logic [CW-1:0] skip_n,
  output logic [31:0]   head,
  output logic [CW-1:0] count,
  output logic          full
);
  localparam int CAP = DEPTH - 1;

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] drop_n;

  always_comb begin
    drop_n = '0;
    if (pop)       drop_n = CW'(1);
    else if (skip) drop_n = skip_n;
  end

  assign head = mem[rp];
  assign full = (count == CW'(CAP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      rp    <= rp + drop_n[AW-1:0];
      count <= count + CW'(push) - drop_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp] <= din;
  end

endmodule

// File: rtl/rxq_reader.sv
// Register read sequencer: word budget, destination holding register, error pulses.
module rxq_reader
  import rxq_pkg::*;
#(
  parameter int CW    = 5,
  parameter int LW    = 7,
  parameter int DESTW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             rd_en,
  input  logic [7:0]       rd_addr,
  input  logic [31:0]      head,
  input  logic [CW-1:0]    store_cnt,
  input  logic [LW-1:0]    len_head,
  input  logic             len_empty,
  input  logic [DESTW-1:0] dest_head,
  input  logic             dest_empty,
  output logic             store_pop,
  output logic             store_skip,
  output logic [CW-1:0]    remain,
  output logic             len_pop,
  output logic             dest_pop,
  output logic [31:0]      rd_data,
  output logic             err_over_read,
  output logic             err_under_read,
  output logic             err_empty
);
  sel_e             sel;
  logic             dest_valid;
  logic [DESTW-1:0] dest_hold;
  logic [LW-1:0]    len_words;

  assign sel        = decode_sel(rd_addr);
  assign len_words  = (len_head + LW'(3)) >> 2;
  assign store_pop  = !flush && rd_en && (sel == SEL_DATA) && (store_cnt != '0) && (remain != '0);
  assign store_skip = !flush && rd_en && (sel == SEL_LEN) && (remain != '0);
  assign len_pop    = !flush && rd_en && (sel == SEL_LEN) && !len_empty;
  assign dest_pop   = !flush && !dest_valid && !dest_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data        <= '0;
      remain         <= '0;
      dest_valid     <= 1'b0;
      dest_hold      <= '0;
      err_over_read  <= 1'b0;
      err_under_read <= 1'b0;
      err_empty      <= 1'b0;
    end else if (flush) begin
      rd_data        <= '0;
      remain         <= '0;
      dest_valid     <= 1'b0;
      dest_hold      <= '0;
      err_over_read  <= 1'b0;
      err_under_read <= 1'b0;
      err_empty      <= 1'b0;
    end else begin
      rd_data        <= '0;
      err_over_read  <= 1'b0;
      err_under_read <= 1'b0;
      err_empty      <= 1'b0;
      if (dest_pop) begin
        dest_hold  <= dest_head;
        dest_valid <= 1'b1;
      end
      if (rd_en) begin
        case (sel)
          SEL_OCC: rd_data <= 32'(store_cnt) + 32'd1;
          SEL_DATA: begin
            if (store_cnt == '0)   err_empty <= 1'b1;
            else if (remain == '0) err_over_read <= 1'b1;
            else begin
              rd_data <= head;
              remain  <= remain - CW'(1);
            end
          end
          SEL_LEN: begin
            if (remain != '0) err_under_read <= 1'b1;
            if (!len_empty) begin
              rd_data <= 32'(len_head);
              remain  <= CW'(len_words);
            end else begin
              remain  <= '0;
            end
          end
          SEL_DEST: begin
            if (dest_valid) begin
              rd_data    <= 32'(dest_hold);
              dest_valid <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/rxq_chan.sv
module rxq_chan
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int FRAMES = 4,
  parameter int DESTW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_reset,
  input  logic             s_tvalid,
  output logic             s_tready,
  input  logic [31:0]      s_tdata,
  input  logic [3:0]       s_tkeep,
  input  logic             s_tlast,
  input  logic [DESTW-1:0] s_tdest,
  input  logic             rd_en,
  input  logic [7:0]       rd_addr,
  output logic [31:0]      rd_data,
  output logic             evt_rx_done,
  output logic             err_over_read,
  output logic             err_under_read,
  output logic             err_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int LW = CW + 2;

  logic             accept, frame_end;
  logic [CW-1:0]    beats;
  logic [LW-1:0]    frame_len;
  logic             store_full, store_pop, store_skip;
  logic [CW-1:0]    store_cnt, remain;
  logic [31:0]      store_head;
  logic             lenq_full, lenq_empty, lenq_pop;
  logic [LW-1:0]    lenq_head;
  logic             destq_full, destq_empty, destq_pop;
  logic [DESTW-1:0] destq_head;

  assign s_tready  = !rx_reset && !store_full && !lenq_full && !destq_full;
  assign accept    = s_tvalid && s_tready;
  assign frame_end = accept && s_tlast;
  assign frame_len = {beats, 2'b00} + LW'(keep_bytes(s_tkeep));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beats       <= '0;
      evt_rx_done <= 1'b0;
    end else if (rx_reset) begin
      beats       <= '0;
      evt_rx_done <= 1'b0;
    end else begin
      evt_rx_done <= frame_end;
      if (accept) beats <= s_tlast ? '0 : beats + CW'(1);
    end
  end

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (rx_reset),
    .push   (accept),
    .din    (s_tdata),
    .pop    (store_pop),
    .skip   (store_skip),
    .skip_n (remain),
    .head   (store_head),
    .count  (store_cnt),
    .full   (store_full)
  );

  rxq_fifo #(.W(LW), .DEPTH(FRAMES)) u_lenq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (rx_reset),
    .push  (frame_end),
    .din   (frame_len),
    .pop   (lenq_pop),
    .dout  (lenq_head),
    .full  (lenq_full),
    .empty (lenq_empty)
  );

  rxq_fifo #(.W(DESTW), .DEPTH(FRAMES)) u_destq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (rx_reset),
    .push  (frame_end),
    .din   (s_tdest),
    .pop   (destq_pop),
    .dout  (destq_head),
    .full  (destq_full),
    .empty (destq_empty)
  );

  rxq_reader #(.CW(CW), .LW(LW), .DESTW(DESTW)) u_rd (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush          (rx_reset),
    .rd_en          (rd_en),
    .rd_addr        (rd_addr),
    .head           (store_head),
    .store_cnt      (store_cnt),
    .len_head       (lenq_head),
    .len_empty      (lenq_empty),
    .dest_head      (destq_head),
    .dest_empty     (destq_empty),
    .store_pop      (store_pop),
    .store_skip     (store_skip),
    .remain         (remain),
    .len_pop        (lenq_pop),
    .dest_pop       (destq_pop),
    .rd_data        (rd_data),
    .err_over_read  (err_over_read),
    .err_under_read (err_under_read),
    .err_empty      (err_empty)
  );

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk
  import rxq_pkg::*;
#(
  parameter int CW  = 5,
  parameter int CAP = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_reset,
  input logic          s_tvalid,
  input logic          s_tready,
  input logic          s_tlast,
  input logic          rd_en,
  input logic [7:0]    rd_addr,
  input logic [CW-1:0] store_cnt,
  input logic [CW-1:0] remain,
  input logic          evt_rx_done,
  input logic          err_over_read,
  input logic          err_under_read,
  input logic          err_empty
);
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_cnt <= CW'(CAP));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready && s_tlast) |=> evt_rx_done);

  // R7
  over_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rx_reset && rd_addr == OFS_DATA && store_cnt != '0 && remain == '0) |=> err_over_read);

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rx_reset && rd_addr == OFS_DATA && store_cnt == '0) |=> err_empty);

  // R11
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> (store_cnt == '0 && remain == '0 && !evt_rx_done));

  // R12
  one_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_over_read, err_under_read, err_empty}));

endmodule

bind rxq_chan rxq_chk #(.CW(CW), .CAP(DEPTH - 1)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rx_reset       (rx_reset),
  .s_tvalid       (s_tvalid),
  .s_tready       (s_tready),
  .s_tlast        (s_tlast),
  .rd_en          (rd_en),
  .rd_addr        (rd_addr),
  .store_cnt      (store_cnt),
  .remain         (remain),
  .evt_rx_done    (evt_rx_done),
  .err_over_read  (err_over_read),
  .err_under_read (err_under_read),
  .err_empty      (err_empty)
);

// File: tb/sim_rxq_chan.sv
module sim_rxq_chan;
  import rxq_pkg::*;

  localparam int DEPTH  = 16;
  localparam int FRAMES = 4;
  localparam int DESTW  = 4;
  localparam int CAP    = DEPTH - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n, rx_reset, s_tvalid, s_tready, s_tlast, rd_en;
  logic [31:0]      s_tdata, rd_data;
  logic [3:0]       s_tkeep;
  logic [DESTW-1:0] s_tdest;
  logic [7:0]       rd_addr;
  logic             evt_rx_done, err_over_read, err_under_read, err_empty;

  rxq_chan #(.DEPTH(DEPTH), .FRAMES(FRAMES), .DESTW(DESTW)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .s_tkeep(s_tkeep), .s_tlast(s_tlast), .s_tdest(s_tdest),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_rx_done(evt_rx_done), .err_over_read(err_over_read),
    .err_under_read(err_under_read), .err_empty(err_empty)
  );

  int nchk = 0;
  int nerr = 0;

  // reference model state
  logic [31:0]      mq[$];
  int               fl[$];
  logic [DESTW-1:0] dq[$];
  int               remain_m = 0;
  logic             dv_m = 1'b0;
  logic [DESTW-1:0] dh_m = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int ones4(input logic [3:0] k);
    int n = 0;
    for (int i = 0; i < 4; i++) n += int'(k[i]);
    return n;
  endfunction

  function automatic int exp_len(input int nb, input logic [3:0] k);
    return 4 * (nb - 1) + ones4(k);
  endfunction

  function automatic logic [3:0] keep_pick(input int i);
    case (i % 4)
      0: return 4'h1;
      1: return 4'h3;
      2: return 4'h7;
      default: return 4'hF;
    endcase
  endfunction

  task automatic do_rd(input logic [7:0] a, output logic [31:0] d, output logic [2:0] f);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = a;
    @(posedge clk);
    #2;
    d = rd_data;
    f = {err_over_read, err_under_read, err_empty};
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic op_occ(input string tag);
    logic [31:0] d; logic [2:0] f;
    do_rd(OFS_OCC, d, f);
    chk(tag, d, 32'(mq.size() + 1));
    chk(tag, {29'd0, f}, 32'd0);
  endtask

  task automatic op_len(input string tag);
    logic [31:0] d; logic [2:0] f;
    int e; logic un;
    un = (remain_m != 0);
    for (int i = 0; i < remain_m; i++) void'(mq.pop_front());
    if (fl.size() > 0) begin
      e = fl.pop_front();
      remain_m = (e + 3) / 4;
    end else begin
      e = 0;
      remain_m = 0;
    end
    do_rd(OFS_LEN, d, f);
    chk(tag, d, 32'(e));
    chk(tag, {29'd0, f}, {29'd0, 1'b0, un, 1'b0});
  endtask

  task automatic op_data(input string tag);
    logic [31:0] d; logic [2:0] f;
    logic [31:0] e; logic [2:0] ef;
    if (mq.size() == 0) begin
      e = '0; ef = 3'b001;
    end else if (remain_m == 0) begin
      e = '0; ef = 3'b100;
    end else begin
      e = mq.pop_front(); ef = 3'b000;
      remain_m--;
    end
    do_rd(OFS_DATA, d, f);
    chk(tag, d, e);
    chk(tag, {29'd0, f}, {29'd0, ef});
  endtask

  task automatic op_dest(input string tag);
    logic [31:0] d; logic [2:0] f;
    logic [31:0] e;
    if (!dv_m && dq.size() > 0) begin
      dh_m = dq.pop_front();
      dv_m = 1'b1;
    end
    if (dv_m) begin
      e = 32'(dh_m);
      dv_m = 1'b0;
    end else e = '0;
    do_rd(OFS_DEST, d, f);
    chk(tag, d, e);
    chk(tag, {29'd0, f}, 32'd0);
  endtask

  task automatic send_frame(input int nb, input logic [3:0] klast,
                            input logic [DESTW-1:0] dest, input logic close);
    for (int b = 0; b < nb; b++) begin
      logic last;
      last = close && (b == nb - 1);
      @(negedge clk);
      s_tvalid = 1'b1;
      s_tdata  = $urandom;
      s_tkeep  = last ? klast : 4'hF;
      s_tlast  = last;
      s_tdest  = dest;
      while (!s_tready) @(negedge clk);
      @(posedge clk);
      mq.push_back(s_tdata);
      #2;
      chk("R4", {31'd0, evt_rx_done}, {31'd0, last});
    end
    @(negedge clk);
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
    if (close) begin
      fl.push_back(exp_len(nb, klast));
      dq.push_back(dest);
    end
    @(negedge clk);
  endtask

  task automatic do_rx_reset();
    @(negedge clk);
    rx_reset = 1'b1;
    @(negedge clk);
    rx_reset = 1'b0;
    mq.delete();
    fl.delete();
    dq.delete();
    remain_m = 0;
    dv_m = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(64'd20 * 64'd150000);
    nchk++;
    nerr++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [31:0] d; logic [2:0] f;
    void'($urandom(32'd2024));
    rst_n = 1'b0; rx_reset = 1'b0; s_tvalid = 1'b0; s_tlast = 1'b0;
    s_tdata = '0; s_tkeep = '0; s_tdest = '0; rd_en = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", {31'd0, s_tready}, 32'd1);
    op_occ("R1");
    op_len("R1");
    op_dest("R1");
    // R8 empty read
    op_data("R8");
    // R12 unmapped offset
    do_rd(8'h04, d, f);
    chk("R12", d, 32'd0);
    chk("R12", {29'd0, f}, 32'd0);

    // R2 R5 R6 R7: one frame, read before length, beyond length
    send_frame(3, 4'h7, 4'd5, 1'b1);
    op_occ("R2");
    op_data("R7");
    op_len("R5");
    for (int i = 0; i < 3; i++) op_data("R6");
    op_data("R7");
    op_occ("R2");
    op_dest("R10");
    op_dest("R10");

    // R10 ordering over two packets
    send_frame(1, 4'h1, 4'd9, 1'b1);
    send_frame(2, 4'h3, 4'd2, 1'b1);
    op_dest("R10");
    op_len("R5");
    op_data("R6");
    op_len("R5");
    op_dest("R10");
    op_data("R6");
    op_data("R6");

    // R9 under-read discards rest of frame
    send_frame(4, 4'hF, 4'd1, 1'b1);
    send_frame(2, 4'h1, 4'd3, 1'b1);
    op_len("R9");
    op_data("R9");
    op_len("R9");
    op_occ("R9");
    op_data("R9");
    op_data("R9");
    op_dest("R10");
    op_dest("R10");

    // R3 store full
    send_frame(CAP, 4'hF, 4'd7, 1'b1);
    chk("R3", {31'd0, s_tready}, 32'd0);
    op_occ("R3");
    op_len("R3");
    for (int i = 0; i < CAP; i++) op_data("R3");
    chk("R3", {31'd0, s_tready}, 32'd1);
    op_dest("R3");

    // R3 packet queue full
    for (int i = 0; i < FRAMES; i++) send_frame(1, 4'h3, 4'(i), 1'b1);
    chk("R3", {31'd0, s_tready}, 32'd0);
    for (int i = 0; i < FRAMES; i++) begin
      op_len("R3");
      op_data("R3");
      op_dest("R3");
    end
    chk("R3", {31'd0, s_tready}, 32'd1);

    // R11 receive reset with a complete and a partial packet pending
    send_frame(2, 4'hF, 4'd4, 1'b1);
    send_frame(2, 4'hF, 4'd6, 1'b0);
    do_rx_reset();
    op_occ("R11");
    op_len("R11");
    op_dest("R11");
    send_frame(1, 4'h1, 4'd8, 1'b1);
    op_len("R11");
    op_data("R11");
    op_dest("R11");

    // constrained random traffic
    for (int it = 0; it < 40; it++) begin
      int nf;
      int nbs[3];
      nf = 1 + int'($urandom % 3);
      for (int k = 0; k < nf; k++) begin
        nbs[k] = 1 + int'($urandom % 4);
        send_frame(nbs[k], keep_pick(int'($urandom % 4)), 4'($urandom), 1'b1);
      end
      if ($urandom % 10 == 0) do_rx_reset();
      for (int k = 0; k < nf; k++) begin
        int nw, mode;
        op_occ("R2");
        op_dest("R10");
        op_len("R5");
        nw = remain_m;
        mode = int'($urandom % 4);
        if (mode == 0 && nw > 1) nw = nw - 1;
        else if (mode == 1) nw = nw + 1;
        for (int w = 0; w < nw; w++) op_data("R6");
      end
    end
    op_len("R9");
    op_data("R8");
    op_occ("R1");

    finish_run();
  end

endmodule